// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port synchronous memory of 2^AW words of DW bits. It has two ports, left and right, and each one has its own clock and reset. Either port can read or write any word while the other port is also active, and that includes the case where both ports use the same word. All address, control and write-data inputs of a port are captured on the rising edge of that port's clock. A port is selected only while its active-high enable is high and its active-low enable is low. This pair of enables lets several instances be stacked for more depth.

Each port holds its current address in a small counter. A clear input sets the counter to zero. A load input copies the external address into the counter. An advance input steps the counter by one. A burst therefore needs one address load, and after that only advance pulses. The address that an access uses is the counter value that the edge produces, so a load, clear or advance applies to the access in that same cycle.

A mode pin on each port picks the read timing. In flow-through mode the data appears one cycle after the address is sampled. Pipelined mode adds one more output register. The read side is a valid-only stream: `rvalid` marks each cycle that carries a read word, and the port has no ready input. Memory reads cannot stall, so the consumer must take the word in the cycle it is valid. The output enable is combinational and gates `rvalid` only. The clock edge that samples the mode also samples the access, so a mode change applies from the next access onward.

Top module: `dpram_burst_top`

## Requirements
- R1: Both ports can access memory in the same cycle, including reads of one address from both ports and writes from the two ports to different addresses. If one port writes an address while the other port reads it, the read returns either the old or the new word.
- R2: A selected cycle with the write input high stores the write data at the effective address on that edge. A later read of that address returns the word from either port, starting with the next cycle.
- R3: In flow-through mode (mode input = 0), a selected cycle with the write input low raises `rvalid` (when the output enable is high) and presents the word on `rdata`, both in the cycle that follows the sampling edge.
- R4: In pipelined mode (mode input = 1), the read word and `rvalid` appear one cycle later than in flow-through mode. The pipelined output register keeps its value through any cycle that carries no selected read.
- R5: When load is high, the external address becomes the effective address of the current access, and the counter keeps that address.
- R6: When advance is high and neither clear nor load is high, the effective address is the counter plus one.
- R7: Counter priority is clear, then load, then advance. Clear gives address zero. When none of the three is high, the access repeats the held address.
- R8: Advancing from address 2^AW-1 gives address 0.
- R9: The port is selected only when its active-high enable is 1 and its active-low enable is 0. A deselected cycle writes nothing and raises no `rvalid`. The counter still follows clear, load and advance while the port is deselected.
- R10: The output enable acts combinationally. While it is low, `rvalid` is low. Raising it in the same cycle raises `rvalid` for a pending read.
- R11: During reset and after it, `rvalid` is low and the counter is zero. A read with no counter control issued after reset accesses address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port reset, active low |
| ce_l | input | 1 | Left enable, active high |
| ce_l_n | input | 1 | Left enable, active low |
| we_l | input | 1 | Left write (1) or read (0) |
| oe_l | input | 1 | Left output enable, gates rvalid_l |
| ld_l | input | 1 | Left counter load from addr_l |
| adv_l | input | 1 | Left counter advance |
| clr_l | input | 1 | Left counter clear |
| pipe_l | input | 1 | Left mode: 0 flow-through, 1 pipelined |
| addr_l | input | AW | Left external address |
| wdata_l | input | DW | Left write data |
| rdata_l | output | DW | Left read data |
| rvalid_l | output | 1 | Left read data valid |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port reset, active low |
| ce_r | input | 1 | Right enable, active high |
| ce_r_n | input | 1 | Right enable, active low |
| we_r | input | 1 | Right write (1) or read (0) |
| oe_r | input | 1 | Right output enable, gates rvalid_r |
| ld_r | input | 1 | Right counter load from addr_r |
| adv_r | input | 1 | Right counter advance |
| clr_r | input | 1 | Right counter clear |
| pipe_r | input | 1 | Right mode: 0 flow-through, 1 pipelined |
| addr_r | input | AW | Right external address |
| wdata_r | input | DW | Right write data |
| rdata_r | output | DW | Right read data |
| rvalid_r | output | 1 | Right read data valid |

## Verification
A table of bursts on the left port drives each counter control on its own. It then drives clear, load and advance together in overlapping combinations, so that a wrong priority returns a different stored word. It also includes a write burst that runs past the top address, which separates correct wrap-around from a write that is lost or misplaced. Directed cases then check several port interactions:
- Both ports read the same word at once.
- The two ports write different words in one cycle and then read each other's word.
- A pipelined read is followed by idle cycles, which tells the extra latency apart from the register hold.
- Writes and loads arrive through each enable separately while the port is deselected.
- The output enable toggles inside a cycle.
- A mid-run reset is followed by a plain read, which shows the counter returning to zero.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_STEP = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_ZERO = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/dpram_xor_bank.sv
// One bank of the two-bank XOR memory. Only one clock writes it, and it has
// NRD asynchronous read ports.
module dpram_xor_bank #(
  parameter int AW  = 10,
  parameter int DW  = 9,
  parameter int NRD = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Both banks start out equal, so every word begins as zero.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/dpram_port_ctl.sv
// Per-port input capture and burst address counter.
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          we,
  input  logic          ld,
  input  logic          adv,
  input  logic          clr,
  input  logic          pipe,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] cur_addr,
  output logic          wr_go,
  output logic          rd_q,
  output logic          pipe_q
);
  ctr_op_e       op;
  logic [AW-1:0] cnt_q;
  logic          sel;

  assign sel = ce_hi & ~ce_lo_n;

  always_comb begin
    if (clr)      op = CTR_ZERO;
    else if (ld)  op = CTR_LOAD;
    else if (adv) op = CTR_STEP;
    else          op = CTR_HOLD;
  end

  always_comb begin
    unique case (op)
      CTR_ZERO: eff_addr = '0;
      CTR_LOAD: eff_addr = addr;
      CTR_STEP: eff_addr = cnt_q + AW'(1);
      default:  eff_addr = cnt_q;
    endcase
  end

  // The write lands on the sampling edge at the effective address.
  assign wr_go    = sel & we;
  assign cur_addr = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      pipe_q <= 1'b0;
    end else begin
      cnt_q  <= eff_addr;
      rd_q   <= sel & ~we;
      pipe_q <= pipe;
    end
  end
endmodule

// File: rtl/dpram_out_stage.sv
// Read path: flow-through or one extra output register.
module dpram_out_stage #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_q,
  input  logic          pipe_q,
  input  logic          oe,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] po_q;
  logic          pv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      po_q <= '0;
      pv_q <= 1'b0;
    end else begin
      if (rd_q) po_q <= word;
      pv_q <= rd_q;
    end
  end

  assign rdata  = pipe_q ? po_q : word;
  assign rvalid = oe & (pipe_q ? pv_q : rd_q);
endmodule

// File: rtl/dpram_burst_top.sv
module dpram_burst_top
  import dpram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk_l,
  input  logic          rst_l_n,
  input  logic          ce_l,
  input  logic          ce_l_n,
  input  logic          we_l,
  input  logic          oe_l,
  input  logic          ld_l,
  input  logic          adv_l,
  input  logic          clr_l,
  input  logic          pipe_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata_l,
  output logic          rvalid_l,
  input  logic          clk_r,
  input  logic          rst_r_n,
  input  logic          ce_r,
  input  logic          ce_r_n,
  input  logic          we_r,
  input  logic          oe_r,
  input  logic          ld_r,
  input  logic          adv_r,
  input  logic          clr_r,
  input  logic          pipe_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wdata_r,
  output logic [DW-1:0] rdata_r,
  output logic          rvalid_r
);
  // Read port 0 of each bank serves the other port's write; ports 1.. serve reads.
  localparam int NRD = NPORT + 1;

  logic [NPORT-1:0]                    clk_v, rst_v, ceh_v, cel_v, we_v, oe_v;
  logic [NPORT-1:0]                    ld_v, adv_v, clr_v, pipe_v;
  logic [NPORT-1:0]                    wr_v, rdq_v, pipeq_v, rvalid_v;
  logic [NPORT-1:0][AW-1:0]            addr_v, eff_v, cur_v;
  logic [NPORT-1:0][DW-1:0]            wd_v, word_v, rdata_v;
  logic [NPORT-1:0][NRD-1:0][AW-1:0]   bk_ra;
  logic [NPORT-1:0][NRD-1:0][DW-1:0]   bk_rd;

  assign clk_v  = {clk_r,   clk_l};
  assign rst_v  = {rst_r_n, rst_l_n};
  assign ceh_v  = {ce_r,    ce_l};
  assign cel_v  = {ce_r_n,  ce_l_n};
  assign we_v   = {we_r,    we_l};
  assign oe_v   = {oe_r,    oe_l};
  assign ld_v   = {ld_r,    ld_l};
  assign adv_v  = {adv_r,   adv_l};
  assign clr_v  = {clr_r,   clr_l};
  assign pipe_v = {pipe_r,  pipe_l};
  assign addr_v = {addr_r,  addr_l};
  assign wd_v   = {wdata_r, wdata_l};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpram_port_ctl #(.AW(AW)) u_ctl (
      .clk      (clk_v[p]),
      .rst_n    (rst_v[p]),
      .ce_hi    (ceh_v[p]),
      .ce_lo_n  (cel_v[p]),
      .we       (we_v[p]),
      .ld       (ld_v[p]),
      .adv      (adv_v[p]),
      .clr      (clr_v[p]),
      .pipe     (pipe_v[p]),
      .addr     (addr_v[p]),
      .eff_addr (eff_v[p]),
      .cur_addr (cur_v[p]),
      .wr_go    (wr_v[p]),
      .rd_q     (rdq_v[p]),
      .pipe_q   (pipeq_v[p])
    );

    // Bank p is written only by port p: stored = data ^ other bank's word.
    assign bk_ra[p][0] = eff_v[NPORT-1-p];
    for (genvar q = 0; q < NPORT; q++) begin : g_ra
      assign bk_ra[p][q+1] = cur_v[q];
    end

    dpram_xor_bank #(.AW(AW), .DW(DW), .NRD(NRD)) u_bank (
      .clk   (clk_v[p]),
      .we    (wr_v[p]),
      .waddr (eff_v[p]),
      .wdata (wd_v[p] ^ bk_rd[NPORT-1-p][0]),
      .raddr (bk_ra[p]),
      .rdata (bk_rd[p])
    );

    assign word_v[p] = bk_rd[0][p+1] ^ bk_rd[1][p+1];

    dpram_out_stage #(.DW(DW)) u_out (
      .clk    (clk_v[p]),
      .rst_n  (rst_v[p]),
      .rd_q   (rdq_v[p]),
      .pipe_q (pipeq_v[p]),
      .oe     (oe_v[p]),
      .word   (word_v[p]),
      .rdata  (rdata_v[p]),
      .rvalid (rvalid_v[p])
    );
  end

  assign rdata_l  = rdata_v[0];
  assign rdata_r  = rdata_v[1];
  assign rvalid_l = rvalid_v[0];
  assign rvalid_r = rvalid_v[1];
endmodule

// File: rtl/dpram_burst_chk.sv
// Per-port protocol checks, bound once per port.
module dpram_burst_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_hi,
  input logic          ce_lo_n,
  input logic          we,
  input logic          oe,
  input logic          pipe,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  logic sel;
  assign sel = ce_hi & ~ce_lo_n;

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rvalid);

  assert_flow_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && !pipe) |=> (rvalid == oe));

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !pipe) |=> !rvalid);

  assert_pipe_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && pipe) ##1 pipe |=> (rvalid == oe));

  assert_pipe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && !we) && pipe) ##1 pipe |=> $stable(rdata));
endmodule

bind dpram_burst_top dpram_burst_chk #(.DW(DW)) u_chk_l (
  .clk(clk_l), .rst_n(rst_l_n), .ce_hi(ce_l), .ce_lo_n(ce_l_n), .we(we_l),
  .oe(oe_l), .pipe(pipe_l), .rdata(rdata_l), .rvalid(rvalid_l)
);

bind dpram_burst_top dpram_burst_chk #(.DW(DW)) u_chk_r (
  .clk(clk_r), .rst_n(rst_r_n), .ce_hi(ce_r), .ce_lo_n(ce_r_n), .we(we_r),
  .oe(oe_r), .pipe(pipe_r), .rdata(rdata_r), .rvalid(rvalid_r)
);

// File: tb/tb_dpram_burst_top.sv
module tb_dpram_burst_top;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int CLK_NS = 20;
  localparam int NVEC = 14;

  // Vector: {we, ld, adv, clr, addr[9:0], wdata[8:0], exp_valid, exp_data[8:0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {4'b1001, 10'd0,    9'h0AA, 1'b0, 9'h000},  // R7 clear, write 0
    {4'b1100, 10'd5,    9'h1A5, 1'b0, 9'h000},  // R5 load, write 5
    {4'b1010, 10'd0,    9'h0F3, 1'b0, 9'h000},  // R6 step, write 6
    {4'b1010, 10'd0,    9'h155, 1'b0, 9'h000},  // R6 step, write 7
    {4'b0100, 10'd5,    9'h000, 1'b1, 9'h1A5},  // R5 load read 5
    {4'b0010, 10'd0,    9'h000, 1'b1, 9'h0F3},  // R6 step read 6
    {4'b0000, 10'd0,    9'h000, 1'b1, 9'h0F3},  // R7 hold read 6
    {4'b0010, 10'd0,    9'h000, 1'b1, 9'h155},  // R6 step read 7
    {4'b0111, 10'd5,    9'h000, 1'b1, 9'h0AA},  // R7 clear wins
    {4'b0110, 10'd5,    9'h000, 1'b1, 9'h1A5},  // R7 load beats step
    {4'b1100, 10'd1023, 9'h1FF, 1'b0, 9'h000},  // R2 write top
    {4'b1010, 10'd0,    9'h033, 1'b0, 9'h000},  // R8 wrap write 0
    {4'b0100, 10'd1023, 9'h000, 1'b1, 9'h1FF},  // R2 read top
    {4'b0010, 10'd0,    9'h000, 1'b1, 9'h033}   // R8 wrap read 0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_l, ce_l_n, we_l, oe_l, ld_l, adv_l, clr_l, pipe_l;
  logic ce_r, ce_r_n, we_r, oe_r, ld_r, adv_r, clr_r, pipe_r;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] wdata_l, wdata_r, rdata_l, rdata_r;
  logic rvalid_l, rvalid_r;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dpram_burst_top #(.AW(AW), .DW(DW)) dut (
    .clk_l(clk), .rst_l_n(rst_n), .ce_l(ce_l), .ce_l_n(ce_l_n), .we_l(we_l),
    .oe_l(oe_l), .ld_l(ld_l), .adv_l(adv_l), .clr_l(clr_l), .pipe_l(pipe_l),
    .addr_l(addr_l), .wdata_l(wdata_l), .rdata_l(rdata_l), .rvalid_l(rvalid_l),
    .clk_r(clk), .rst_r_n(rst_n), .ce_r(ce_r), .ce_r_n(ce_r_n), .we_r(we_r),
    .oe_r(oe_r), .ld_r(ld_r), .adv_r(adv_r), .clr_r(clr_r), .pipe_r(pipe_r),
    .addr_r(addr_r), .wdata_r(wdata_r), .rdata_r(rdata_r), .rvalid_r(rvalid_r)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    ce_l = 1; ce_l_n = 0; we_l = 0; oe_l = 1; ld_l = 0; adv_l = 0; clr_l = 0;
    addr_l = '0; wdata_l = '0;
    ce_r = 1; ce_r_n = 0; we_r = 0; oe_r = 1; ld_r = 0; adv_r = 0; clr_r = 0;
    addr_r = '0; wdata_r = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    quiet(); pipe_l = 0; pipe_r = 0; ce_l = 0; ce_r = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset rvalid_l", 16'(rvalid_l), 16'd0);
    chk("R11 reset rvalid_r", 16'(rvalid_r), 16'd0);
    rst_n = 1;
    @(negedge clk);

    // Vector table on the left port, flow-through mode.
    quiet(); ce_r = 0;
    for (int i = 0; i < NVEC; i++) begin
      {we_l, ld_l, adv_l, clr_l} = VEC[i][32:29];
      addr_l  = VEC[i][28:19];
      wdata_l = VEC[i][18:10];
      @(negedge clk);
      chk($sformatf("R2-table vec %0d valid", i), 16'(rvalid_l), 16'(VEC[i][9]));
      if (VEC[i][9])
        chk($sformatf("R5/R6/R7/R8 vec %0d data", i), 16'(rdata_l), 16'(VEC[i][8:0]));
    end

    // R1: both ports read address 5 together.
    quiet(); ld_l = 1; addr_l = 10'd5; ld_r = 1; addr_r = 10'd5;
    @(negedge clk);
    chk("R1 left same addr", 16'(rdata_l), 16'h1A5);
    chk("R1 right same addr", 16'(rdata_r), 16'h1A5);
    // R1/R2: simultaneous writes, then cross reads.
    quiet(); we_l = 1; ld_l = 1; addr_l = 10'd100; wdata_l = 9'h011;
    we_r = 1; ld_r = 1; addr_r = 10'd200; wdata_r = 9'h022;
    @(negedge clk);
    quiet(); ld_l = 1; addr_l = 10'd200; ld_r = 1; addr_r = 10'd100;
    @(negedge clk);
    chk("R1 left sees right write", 16'(rdata_l), 16'h022);
    chk("R2 right sees left write", 16'(rdata_r), 16'h011);

    // R4: pipelined read on the left.
    quiet(); ce_r = 0; ce_l = 0; pipe_l = 1;
    @(negedge clk);
    quiet(); ce_r = 0; ld_l = 1; addr_l = 10'd6;
    @(negedge clk);
    chk("R4 pipe no early valid", 16'(rvalid_l), 16'd0);
    quiet(); ce_r = 0; ce_l = 0;
    @(negedge clk);
    chk("R4 pipe valid", 16'(rvalid_l), 16'd1);
    chk("R4 pipe data", 16'(rdata_l), 16'h0F3);
    @(negedge clk);
    chk("R4 pipe valid drops", 16'(rvalid_l), 16'd0);
    chk("R4 pipe data held", 16'(rdata_l), 16'h0F3);
    pipe_l = 0;
    @(negedge clk);

    // R9: deselected write is dropped; counter still loads while deselected.
    quiet(); ce_r = 0; ce_l = 0; we_l = 1; ld_l = 1; addr_l = 10'd7; wdata_l = 9'h000;
    @(negedge clk);
    chk("R9 deselect no valid", 16'(rvalid_l), 16'd0);
    quiet(); ce_r = 0; ld_l = 1; addr_l = 10'd7;
    @(negedge clk);
    chk("R9 deselected write ignored", 16'(rdata_l), 16'h155);
    quiet(); ce_r = 0; ce_l_n = 1; ld_l = 1; addr_l = 10'd5;
    @(negedge clk);
    chk("R9 low-active enable deselects", 16'(rvalid_l), 16'd0);
    quiet(); ce_r = 0;
    @(negedge clk);
    chk("R9 counter loaded while deselected", 16'(rdata_l), 16'h1A5);

    // R10: output enable acts within the cycle.
    quiet(); ce_r = 0; ld_l = 1; addr_l = 10'd6; oe_l = 0;
    @(negedge clk);
    chk("R10 oe low masks valid", 16'(rvalid_l), 16'd0);
    oe_l = 1;
    #1;
    chk("R10 oe high valid", 16'(rvalid_l), 16'd1);
    chk("R10 data unaffected", 16'(rdata_l), 16'h0F3);
    @(negedge clk);

    // R11: mid-run reset returns counter to zero.
    quiet(); ce_l = 0; ce_r = 0; rst_n = 0;
    @(negedge clk);
    chk("R11 rvalid low in reset", 16'(rvalid_l), 16'd0);
    rst_n = 1;
    @(negedge clk);
    quiet(); ce_r = 0;
    @(negedge clk);
    chk("R11 counter zero after reset", 16'(rdata_l), 16'h033);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule